// File: doc/BRIEF.md
# Programmed-IO Message Mailbox Registers

This block is the card-side register file behind an eight-port, byte-wide programmed I/O window. A host uses it to pass messages to a peripheral and to collect messages from it. The host addresses a data port, a status register, a control register, an end-of-interrupt port and an interrupt-select register. The status register holds two independent three-bit handshake fields, one for each direction, plus a wake flag and a clear-NAK flag. The host rewrites the whole byte, so a read-modify-write of one field leaves everything else as it was. The card logic sees every field as a decoded output.

The host rings a doorbell toward the card by driving a control interrupt bit low and then high again. Each rising transition produces a single-cycle pulse on the matching doorbell output. Another control bit holds the card in reset for as long as it stays set, and a further control bit widens the data port from a byte to a 16-bit word.

In the other direction, a card-side interrupt request sets a sticky pending flag. While the flag is pending and the interrupt-select enable is set, the block drives the selected one of several interrupt lines. A host read of the end-of-interrupt port clears the flag.

Top module: `pio_mailbox`

## Requirements
- R1: After reset every register reads zero, no interrupt line is driven, and the doorbells, strobes and card reset are all low.
- R2: A host write to offset 2 stores the whole byte, and reads of offset 2 return it. The card outputs take their values from the stored byte: rx_state from bits 6:4, tx_state from bits 2:0, wake from bit 7 and clrnak from bit 3. The handshake codes are 0 idle, 1 high-length available, 2 high-length accepted, 3 done, 4 transferring, 5 error, 6 low-length available and 7 low-length accepted.
- R3: rx_ready is high exactly when rx_state is 1, 5 or 6.
- R4: A host write to offset 4 stores bits 5:0 only. Bits 7:6 read as zero.
- R5: A write to offset 4 that changes bit 0 from 0 to 1 pulses doorbell_rx for one cycle, in the cycle after the write. Bit 1 does the same for doorbell_tx. A write that leaves a bit at 1 produces no pulse.
- R6: card_reset equals control bit 4 from the cycle after the write onward, and wide_mode equals control bit 5.
- R7: A write to offset 0 pulses card_wr_stb in the next cycle, with the written value on card_wr_data. A read of offset 0 pulses card_rd_stb in the same cycle and returns card_rd_data. In byte mode (control bit 5 clear), bits 15:8 are zero in both directions.
- R8: A write to offset 6 stores the line select in bits 2:0 and the enable in bit 4. All other bits read as zero.
- R9: card_irq_req sets a pending flag. While the flag is set and the enable is set, irq_lines has only the bit for the selected line high; otherwise irq_lines is zero.
- R10: A read of offset 5 returns zero and clears the pending flag. If card_irq_req is high in the same cycle, the flag stays set.
- R11: Offsets 1, 3 and 7 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_addr | input | 3 | Host port offset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data (combinational) |
| card_rd_data | input | 16 | Word the card offers at the data port |
| card_rd_stb | output | 1 | Data port read pulse |
| card_wr_stb | output | 1 | Data port write pulse |
| card_wr_data | output | 16 | Data written by the host |
| doorbell_rx | output | 1 | Receive doorbell pulse |
| doorbell_tx | output | 1 | Transmit doorbell pulse |
| card_reset | output | 1 | Card reset/standby hold |
| wide_mode | output | 1 | 16-bit data mode |
| tx_state | output | 3 | Transmit handshake state |
| rx_state | output | 3 | Receive handshake state |
| wake | output | 1 | Wake flag |
| clrnak | output | 1 | Clear-NAK flag |
| rx_ready | output | 1 | Receive state wants host attention |
| card_irq_req | input | 1 | Card interrupt request |
| irq_lines | output | 8 | Host interrupt lines |

## Verification
The sensitive collision is a card interrupt request that arrives in the same cycle as the host's end-of-interrupt read. If the clear won, that request would be lost. The bench forces this case on purpose, and the random phase also hits it. The behavioural model holds the flag set, and every cycle it compares irq_lines against the select and enable it expects. A second overlap is a control write that rings a doorbell while it also changes the reset or width bit. This is judged by comparing the pulse and the level outputs together in the following cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFF_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_EOI  = 3'd5;
  localparam logic [ADDR_W-1:0] OFF_ISEL = 3'd6;

  typedef enum logic [2:0] {
    HS_IDLE     = 3'd0,
    HS_HI_AVAIL = 3'd1,
    HS_HI_ACC   = 3'd2,
    HS_DONE     = 3'd3,
    HS_XFER     = 3'd4,
    HS_ERR      = 3'd5,
    HS_LO_AVAIL = 3'd6,
    HS_LO_ACC   = 3'd7
  } hs_state_e;

  function automatic logic rx_wants_host(input logic [2:0] st);
    return (st == HS_LO_AVAIL) || (st == HS_HI_AVAIL) || (st == HS_ERR);
  endfunction
endpackage

// File: rtl/mbx_doorbell.sv
module mbx_doorbell #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] new_bits,
  input  logic [N-1:0] old_bits,
  output logic [N-1:0] pulse
);
  for (genvar i = 0; i < N; i++) begin : g_bell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse[i] <= 1'b0;
      else        pulse[i] <= wr_en && new_bits[i] && !old_bits[i];
    end
  end
endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen #(
  parameter int NUM_LINES = 8,
  localparam int SEL_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 eoi,
  input  logic                 en,
  input  logic [SEL_W-1:0]     sel,
  output logic                 pending,
  output logic [NUM_LINES-1:0] lines
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pending <= 1'b0;
    else if (req) pending <= 1'b1;
    else if (eoi) pending <= 1'b0;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign lines[i] = pending && en && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/pio_mailbox.sv
module pio_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    hst_addr,
  input  logic                 hst_wr,
  input  logic                 hst_rd,
  input  logic [DATA_W-1:0]    hst_wdata,
  output logic [DATA_W-1:0]    hst_rdata,
  input  logic [DATA_W-1:0]    card_rd_data,
  output logic                 card_rd_stb,
  output logic                 card_wr_stb,
  output logic [DATA_W-1:0]    card_wr_data,
  output logic                 doorbell_rx,
  output logic                 doorbell_tx,
  output logic                 card_reset,
  output logic                 wide_mode,
  output logic [2:0]           tx_state,
  output logic [2:0]           rx_state,
  output logic                 wake,
  output logic                 clrnak,
  output logic                 rx_ready,
  input  logic                 card_irq_req,
  output logic [NUM_LINES-1:0] irq_lines
);
  localparam int BYTE_W = 8;
  localparam int CTRL_W = 6;
  localparam int SEL_W  = $clog2(NUM_LINES);
  localparam int EN_BIT = 4;

  function automatic logic [DATA_W-1:0] lane_fit(input logic wide, input logic [DATA_W-1:0] v);
    return wide ? v : {{(DATA_W-BYTE_W){1'b0}}, v[BYTE_W-1:0]};
  endfunction

  logic [BYTE_W-1:0] status_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              isel_en_q;
  logic [SEL_W-1:0]  isel_sel_q;
  logic              irq_pending;

  // named events for the checker
  logic wr_data, wr_stat, wr_ctrl, wr_isel, rd_data, eoi_rd, irq_en;
  assign wr_data = hst_wr && (hst_addr == OFF_DATA);
  assign wr_stat = hst_wr && (hst_addr == OFF_STAT);
  assign wr_ctrl = hst_wr && (hst_addr == OFF_CTRL);
  assign wr_isel = hst_wr && (hst_addr == OFF_ISEL);
  assign rd_data = hst_rd && (hst_addr == OFF_DATA);
  assign eoi_rd  = hst_rd && (hst_addr == OFF_EOI);
  assign irq_en  = isel_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q   <= '0;
      ctrl_q     <= '0;
      isel_en_q  <= 1'b0;
      isel_sel_q <= '0;
    end else begin
      if (wr_stat) status_q <= hst_wdata[BYTE_W-1:0];
      if (wr_ctrl) ctrl_q   <= hst_wdata[CTRL_W-1:0];
      if (wr_isel) begin
        isel_en_q  <= hst_wdata[EN_BIT];
        isel_sel_q <= hst_wdata[SEL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      card_wr_stb  <= 1'b0;
      card_wr_data <= '0;
    end else begin
      card_wr_stb <= wr_data;
      if (wr_data) card_wr_data <= lane_fit(ctrl_q[5], hst_wdata);
    end
  end

  logic [1:0] bells;
  mbx_doorbell #(.N(2)) u_bell (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_ctrl),
    .new_bits (hst_wdata[1:0]),
    .old_bits (ctrl_q[1:0]),
    .pulse    (bells)
  );
  assign doorbell_rx = bells[0];
  assign doorbell_tx = bells[1];

  mbx_irq_gen #(.NUM_LINES(NUM_LINES)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (card_irq_req),
    .eoi     (eoi_rd),
    .en      (isel_en_q),
    .sel     (isel_sel_q),
    .pending (irq_pending),
    .lines   (irq_lines)
  );

  assign card_reset  = ctrl_q[4];
  assign wide_mode   = ctrl_q[5];
  assign tx_state    = status_q[2:0];
  assign rx_state    = status_q[6:4];
  assign clrnak      = status_q[3];
  assign wake        = status_q[7];
  assign rx_ready    = rx_wants_host(status_q[6:4]);
  assign card_rd_stb = rd_data;

  logic [BYTE_W-1:0] isel_view;
  always_comb begin
    isel_view = '0;
    isel_view[EN_BIT] = isel_en_q;
    isel_view[SEL_W-1:0] = isel_sel_q;
  end

  always_comb begin
    hst_rdata = '0;
    unique case (hst_addr)
      OFF_DATA: hst_rdata = lane_fit(ctrl_q[5], card_rd_data);
      OFF_STAT: hst_rdata[BYTE_W-1:0] = status_q;
      OFF_CTRL: hst_rdata[CTRL_W-1:0] = ctrl_q;
      OFF_ISEL: hst_rdata[BYTE_W-1:0] = isel_view;
      default:  hst_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pio_mailbox_chk.sv
module pio_mailbox_chk #(
  parameter int DATA_W    = 16,
  parameter int NUM_LINES = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hst_wr,
  input logic [2:0]           hst_addr,
  input logic [DATA_W-1:0]    hst_wdata,
  input logic                 card_irq_req,
  input logic                 eoi_rd,
  input logic                 irq_en,
  input logic                 doorbell_rx,
  input logic                 doorbell_tx,
  input logic                 card_reset,
  input logic                 wide_mode,
  input logic                 card_wr_stb,
  input logic [DATA_W-1:0]    card_wr_data,
  input logic [2:0]           rx_state,
  input logic                 rx_ready,
  input logic [NUM_LINES-1:0] irq_lines
);
  AST_RX_BELL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell_rx |-> $past(hst_wr && hst_addr == 3'd4 && hst_wdata[0])); // R5
  AST_TX_BELL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell_tx |-> $past(hst_wr && hst_addr == 3'd4 && hst_wdata[1])); // R5
  AST_BELL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell_rx |=> !doorbell_rx); // R5
  AST_RESET_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && hst_addr == 3'd4) |=> card_reset == $past(hst_wdata[4])); // R6
  AST_LINE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines)); // R9
  AST_LINE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> irq_lines == '0); // R9
  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_rd && !card_irq_req) |=> irq_lines == '0); // R10
  AST_REQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (card_irq_req && irq_en && !(hst_wr && hst_addr == 3'd6)) |=> $countones(irq_lines) == 1); // R10
  AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (card_wr_stb && !wide_mode) |-> card_wr_data[DATA_W-1:8] == '0); // R7
  AST_READY_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (rx_state == 3'd1 || rx_state == 3'd5 || rx_state == 3'd6)); // R3
endmodule

bind pio_mailbox pio_mailbox_chk #(.DATA_W(DATA_W), .NUM_LINES(NUM_LINES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hst_wr       (hst_wr),
  .hst_addr     (hst_addr),
  .hst_wdata    (hst_wdata),
  .card_irq_req (card_irq_req),
  .eoi_rd       (eoi_rd),
  .irq_en       (irq_en),
  .doorbell_rx  (doorbell_rx),
  .doorbell_tx  (doorbell_tx),
  .card_reset   (card_reset),
  .wide_mode    (wide_mode),
  .card_wr_stb  (card_wr_stb),
  .card_wr_data (card_wr_data),
  .rx_state     (rx_state),
  .rx_ready     (rx_ready),
  .irq_lines    (irq_lines)
);

// File: tb/pio_mailbox_bench.sv
`timescale 1ns/1ps
module pio_mailbox_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  hst_addr = '0;
  logic        hst_wr = 1'b0, hst_rd = 1'b0;
  logic [15:0] hst_wdata = '0;
  logic [15:0] hst_rdata;
  logic [15:0] card_rd_data = '0;
  logic        card_rd_stb, card_wr_stb;
  logic [15:0] card_wr_data;
  logic        doorbell_rx, doorbell_tx, card_reset, wide_mode;
  logic [2:0]  tx_state, rx_state;
  logic        wake, clrnak, rx_ready;
  logic        card_irq_req = 1'b0;
  logic [7:0]  irq_lines;

  always #2 clk = ~clk;

  pio_mailbox u_pio_mailbox (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  int m_stat, m_ctrl, m_isel, m_pend, m_bell_rx, m_bell_tx, m_wstb, m_wdat;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_ready(input int st);
    case (st)
      1, 5, 6: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic compare_regs();
    chk("R2 tx_state", tx_state, m_stat & 7);
    chk("R2 rx_state", rx_state, (m_stat >> 4) & 7);
    chk("R2 wake", wake, (m_stat >> 7) & 1);
    chk("R2 clrnak", clrnak, (m_stat >> 3) & 1);
    chk("R3 rx_ready", rx_ready, exp_ready((m_stat >> 4) & 7));
    chk("R5 doorbell_rx", doorbell_rx, m_bell_rx);
    chk("R5 doorbell_tx", doorbell_tx, m_bell_tx);
    chk("R6 card_reset", card_reset, (m_ctrl >> 4) & 1);
    chk("R6 wide_mode", wide_mode, (m_ctrl >> 5) & 1);
    chk("R7 card_wr_stb", card_wr_stb, m_wstb);
    if (m_wstb != 0) chk("R7 card_wr_data", card_wr_data, m_wdat);
    chk("R9 irq_lines", irq_lines,
        (m_pend != 0 && ((m_isel >> 4) & 1) != 0) ? (1 << (m_isel & 7)) : 0);
  endtask

  task automatic step(input bit wr, input bit rd, input int addr, input int wd,
                      input bit req, input int crd);
    int wide, er;
    @(negedge clk);
    compare_regs();
    hst_wr = wr; hst_rd = rd; hst_addr = 3'(addr); hst_wdata = 16'(wd);
    card_irq_req = req; card_rd_data = 16'(crd);
    #1;
    wide = (m_ctrl >> 5) & 1;
    case (addr)
      0: er = wide ? crd & 'hffff : crd & 'hff;
      2: er = m_stat;
      4: er = m_ctrl;
      6: er = m_isel;
      default: er = 0;
    endcase
    if (addr == 0)      chk("R7 data read", hst_rdata, er);
    else if (addr == 2) chk("R2 status read", hst_rdata, er);
    else if (addr == 4) chk("R4 control read", hst_rdata, er);
    else if (addr == 6) chk("R8 intsel read", hst_rdata, er);
    else if (addr == 5) chk("R10 eoi read", hst_rdata, er);
    else                chk("R11 unmapped read", hst_rdata, er);
    chk("R7 card_rd_stb", card_rd_stb, (rd && addr == 0) ? 1 : 0);
    @(posedge clk);
    m_bell_rx = (wr && addr == 4 && (wd & 1) != 0 && (m_ctrl & 1) == 0) ? 1 : 0;
    m_bell_tx = (wr && addr == 4 && (wd & 2) != 0 && (m_ctrl & 2) == 0) ? 1 : 0;
    m_wstb = (wr && addr == 0) ? 1 : 0;
    if (m_wstb != 0) m_wdat = wide ? wd & 'hffff : wd & 'hff;
    if (req) m_pend = 1;
    else if (rd && addr == 5) m_pend = 0;
    if (wr && addr == 2) m_stat = wd & 'hff;
    if (wr && addr == 4) m_ctrl = wd & 'h3f;
    if (wr && addr == 6) m_isel = wd & 'h17;
  endtask

  task automatic wr(input int a, input int d); step(1, 0, a, d, 0, 0); endtask
  task automatic rd(input int a, input int c); step(0, 1, a, 0, 0, c); endtask
  task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask

  initial begin
    m_stat = 0; m_ctrl = 0; m_isel = 0; m_pend = 0;
    m_bell_rx = 0; m_bell_tx = 0; m_wstb = 0; m_wdat = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state at the ports
    chk("R1 irq_lines", irq_lines, 0);
    chk("R1 card_reset", card_reset, 0);
    chk("R1 status", {wake, rx_state, clrnak, tx_state}, 0);
    @(negedge clk) rst_n = 1'b1;
    rd(2, 0); rd(4, 0); rd(6, 0);
    // R2 read-modify-write of each field
    wr(2, 'h06); rd(2, 0);
    wr(2, 'h56); wr(2, 'hD6); wr(2, 'h5E); wr(2, 'h16); wr(2, 'h66); rd(2, 0);
    for (int s = 0; s < 8; s++) wr(2, s << 4); // R3 every rx code
    // R4/R5/R6 control sequences
    wr(4, 'hFF); rd(4, 0); idle();
    wr(4, 'h03); wr(4, 'h00); wr(4, 'h01); wr(4, 'h03); wr(4, 'h02); wr(4, 'h03);
    wr(4, 'h13); idle(); wr(4, 'h00); idle();
    // R7 byte mode then wide mode
    wr(0, 'hABCD); rd(0, 'h1234); idle();
    wr(4, 'h20); wr(0, 'hABCD); rd(0, 'h1234); wr(4, 'h00);
    // R8/R9 interrupts
    wr(6, 'hFB); rd(6, 0);
    step(0, 0, 0, 0, 1, 0); idle(); idle();
    wr(6, 'h05); idle(); wr(6, 'h15);
    rd(5, 0); idle();                       // R10 clear
    step(0, 0, 0, 0, 1, 0);
    step(0, 1, 5, 0, 1, 0); idle();         // R10 request beats eoi
    rd(5, 0); idle();
    // R11 unmapped writes ignored
    wr(2, 'h25); wr(1, 'hFFFF); wr(3, 'hFFFF); wr(7, 'hFFFF);
    rd(2, 0); rd(4, 0); rd(6, 0); rd(1, 0); rd(3, 0); rd(7, 0);
    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      int k;
      k = int'($urandom_range(0, 3));
      step(k == 1, k == 2, int'($urandom_range(0, 7)), int'($urandom_range(0, 'hFFFF)),
           ($urandom_range(0, 7) == 0), int'($urandom_range(0, 'hFFFF)));
    end
    @(negedge clk); compare_regs();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule